// File: doc/BRIEF.md
# Event Interrupt Register with Open-Drain Request Output

This block holds two 16-bit registers that decide when an internal event pulls a shared, active-low interrupt line. The enable register (`cfg_q`) selects which channels may raise the line. Bit 15 of that register gates the line as a whole. The flag register (`isr_q`) records which enabled events have happened. Both registers use inverted polarity. A 0 in the enable register turns a channel on. A 0 in the flag register marks that the channel's event has occurred.

The host can only set flags back to 1. An event is the only thing that can drive a flag to 0. Writing a 1 into an enable bit turns that channel off and also resets its flag. Writing a 1 into bit 15 resets every flag.

The output `int_pd` is a registered pull-down enable for an open-drain pad. The pad pulls low while the line is enabled and at least one enabled flag is 0. Flag bit 2 is the exception: it records a power-on reset and never reaches the line.

The block has two synchronous, active-low reset inputs. The power-on reset and the hardware reset leave different images in the flag register. Bus decoding and event generation sit outside the block.

Top module: `irq_event_ctrl`

## Requirements
- R1: While `por_n` is 0, the next clock edge loads `cfg_q` with FFFFh and `isr_q` with FFFBh (bit 2 at 0) and clears `int_pd`. `por_n` takes priority over `hrst_n`.
- R2: While `hrst_n` is 0 and `por_n` is 1, the next edge loads `cfg_q` with FFFFh and `isr_q` with FFFFh and clears `int_pd`.
- R3: A 1 on `evt[i]` clears `isr_q[i]` at the next edge only if bit i is an event channel (`EVT_MASK`, default bit 4 only) and the enable bit `cfg_q[i]`, taking any same-cycle write into account, is 0. Pulses on other bits, or on disabled channels, leave `isr_q` unchanged.
- R4: A write to the flag register (`isr_wr`) sets `isr_q[i]` to 1 for each `wdata[i]` of 1. A 0 in `wdata` never clears a flag.
- R5: A write to the enable register (`cfg_wr`) loads `wdata` into `cfg_q` at the next edge. Every bit written as 1 also sets the matching `isr_q` bit to 1. `cfg_q` changes only on `cfg_wr` or a reset.
- R6: A write to the enable register with `wdata[15]` at 1 sets all of `isr_q`, bit 2 included, to FFFFh, except for a channel that is left enabled and has an event in the same cycle.
- R7: `int_pd` is 1 one cycle after the registers hold `cfg_q[15]`=0 together with some bit i≠2, i<15, that has both `cfg_q[i]`=0 and `isr_q[i]`=0.
- R8: `isr_q[2]` at 0 never makes `int_pd` 1, even with `cfg_q[2]` and `cfg_q[15]` both at 0.
- R9: `int_pd` returns to 0 one cycle after the last enabled flag is set back to 1.
- R10: When an event and a host write that sets the same flag fall in one cycle, the event wins and the flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| hrst_n | input | 1 | Hardware reset, synchronous, active low |
| cfg_wr | input | 1 | Write strobe for the enable register |
| isr_wr | input | 1 | Write strobe for the flag register |
| wdata | input | 16 | Write data for either register |
| evt | input | 16 | Event pulses, one per channel |
| cfg_q | output | 16 | Enable register read-back |
| isr_q | output | 16 | Flag register read-back |
| int_pd | output | 1 | Pull-down enable for the open-drain interrupt pad |

## Verification
The bench checks the power-on detect flag from three sides. A design that let this flag reach the line would hold the interrupt after every cold start. A design that lost the flag on a hardware reset, or did not clear it on a bit-15 write, would show the wrong flag image.

The bench also writes zeros to the flag register. It expects the flags to stay unchanged, which catches plain write-through logic. It drives an event together with a host set of the same flag, and an event on a disabled or unimplemented channel. These cases expose the wrong priority and missing gating.

Every pin check is sampled one cycle after the register change. A combinational output, or one that lagged by two cycles, would fail these checks.

// File: rtl/irq_event_pkg.sv
// Shared types for the event interrupt block.
// Assumes both resets are synchronous and active low; power-on dominates.
package irq_event_pkg;

    typedef enum logic [1:0] {
        RST_NONE = 2'd0,
        RST_HW   = 2'd1,
        RST_POR  = 2'd2
    } rst_kind_e;

    // Decode the two reset inputs into one reset kind, power-on first.
    function automatic rst_kind_e rst_kind(input logic por_n, input logic hrst_n);
        if (!por_n)       return RST_POR;
        else if (!hrst_n) return RST_HW;
        else              return RST_NONE;
    endfunction

endpackage

// File: rtl/irq_cfg_reg.sv
// Enable register: loads host data on a write and resets to all ones
// (every channel disabled, line disabled) on either reset.
// Also exports the value it will hold after this cycle, for event gating.
module irq_cfg_reg
    import irq_event_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  rst_kind_e    rkind,
    input  logic         cfg_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cfg_nxt,
    output logic [W-1:0] cfg_q
);

    localparam logic [W-1:0] ALL_OFF = {W{1'b1}};

    // Next-state value: a write replaces the register.
    always_comb begin
        cfg_nxt = cfg_wr ? wdata : cfg_q;
    end

    // Register with synchronous reset to all ones.
    always_ff @(posedge clk) begin
        if (rkind != RST_NONE) cfg_q <= ALL_OFF;
        else                   cfg_q <= cfg_nxt;
    end

endmodule

// File: rtl/irq_status_reg.sv
// Flag register, one cell per bit. Host writes and enable-bit writes can
// only set flags to 1. Only an event on an enabled, implemented channel
// clears a flag. An event beats a same-cycle set.
// Assumes cfg_nxt already reflects any same-cycle enable write.
module irq_status_reg
    import irq_event_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           OE_BIT   = 15,
    parameter int           POR_BIT  = 2,
    parameter logic [W-1:0] EVT_MASK = 16'h0010
) (
    input  logic         clk,
    input  rst_kind_e    rkind,
    input  logic         cfg_wr,
    input  logic         isr_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] cfg_nxt,
    output logic [W-1:0] isr_q
);

    // Line-disable write: resets every flag.
    logic oe_off_wr;
    assign oe_off_wr = cfg_wr & wdata[OE_BIT];

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic POR_VAL = (i == POR_BIT) ? 1'b0 : 1'b1;
        logic set_b;
        logic hit_b;

        // Set request from either register write.
        always_comb begin
            set_b = (isr_wr & wdata[i]) | (cfg_wr & wdata[i]) | oe_off_wr;
            hit_b = EVT_MASK[i] & evt[i] & ~cfg_nxt[i];
        end

        // Flag cell: reset image depends on the reset kind; event wins over set.
        always_ff @(posedge clk) begin
            case (rkind)
                RST_POR: isr_q[i] <= POR_VAL;
                RST_HW:  isr_q[i] <= 1'b1;
                default: isr_q[i] <= (isr_q[i] | set_b) & ~hit_b;
            endcase
        end
    end

endmodule

// File: rtl/irq_pin_drv.sv
// Open-drain pull-down request. Asserts when the line is enabled and any
// enabled flag below the enable bit, other than the power-on flag, is 0.
// Registered: follows the register contents with one cycle of latency.
module irq_pin_drv
    import irq_event_pkg::*;
#(
    parameter int W       = 16,
    parameter int OE_BIT  = 15,
    parameter int POR_BIT = 2
) (
    input  logic         clk,
    input  rst_kind_e    rkind,
    input  logic [W-1:0] cfg_q,
    input  logic [W-2:0] isr_lo,
    output logic         int_pd
);

    localparam logic [W-2:0] PIN_MASK = ~((W-1)'(1) << POR_BIT);

    logic req;

    // Combine enabled, flagged channels; exclude the power-on flag.
    always_comb begin
        req = ~cfg_q[OE_BIT] & (|(~cfg_q[W-2:0] & ~isr_lo & PIN_MASK));
    end

    // Pull-down enable register; released by either reset.
    always_ff @(posedge clk) begin
        if (rkind != RST_NONE) int_pd <= 1'b0;
        else                   int_pd <= req;
    end

endmodule

// File: rtl/irq_event_ctrl.sv
// Top of the event interrupt block: enable register, flag register and
// open-drain pull-down request. The enable bit is the register MSB.
// Assumes write strobes and event pulses are single-cycle and synchronous.
module irq_event_ctrl
    import irq_event_pkg::*;
#(
    parameter int           W        = 16,
    parameter int           POR_BIT  = 2,
    parameter logic [W-1:0] EVT_MASK = 16'h0010
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         hrst_n,
    input  logic         cfg_wr,
    input  logic         isr_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] cfg_q,
    output logic [W-1:0] isr_q,
    output logic         int_pd
);

    localparam int OE_BIT = W - 1;

    rst_kind_e    rkind;
    logic [W-1:0] cfg_nxt;

    // Reset kind shared by all registers.
    always_comb begin
        rkind = rst_kind(por_n, hrst_n);
    end

    irq_cfg_reg #(.W(W)) u_cfg (
        .clk     (clk),
        .rkind   (rkind),
        .cfg_wr  (cfg_wr),
        .wdata   (wdata),
        .cfg_nxt (cfg_nxt),
        .cfg_q   (cfg_q)
    );

    irq_status_reg #(
        .W        (W),
        .OE_BIT   (OE_BIT),
        .POR_BIT  (POR_BIT),
        .EVT_MASK (EVT_MASK)
    ) u_isr (
        .clk     (clk),
        .rkind   (rkind),
        .cfg_wr  (cfg_wr),
        .isr_wr  (isr_wr),
        .wdata   (wdata),
        .evt     (evt),
        .cfg_nxt (cfg_nxt),
        .isr_q   (isr_q)
    );

    irq_pin_drv #(
        .W       (W),
        .OE_BIT  (OE_BIT),
        .POR_BIT (POR_BIT)
    ) u_pin (
        .clk    (clk),
        .rkind  (rkind),
        .cfg_q  (cfg_q),
        .isr_lo (isr_q[W-2:0]),
        .int_pd (int_pd)
    );

endmodule

// File: rtl/irq_event_ctrl_chk.sv
// Checker for irq_event_ctrl, bound to every instance of the top.
// Arms one cycle after both resets are high, so $past never sees
// pre-reset values.
module irq_event_ctrl_chk #(
    parameter int           W        = 16,
    parameter int           POR_BIT  = 2,
    parameter logic [W-1:0] EVT_MASK = 16'h0010
) (
    input logic         clk,
    input logic         por_n,
    input logic         hrst_n,
    input logic         cfg_wr,
    input logic         isr_wr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] evt,
    input logic [W-1:0] cfg_q,
    input logic [W-1:0] isr_q,
    input logic         int_pd
);

    localparam logic [W-1:0] POR_ONE = W'(1) << POR_BIT;

    logic live = 1'b0;

    // Arm flag: high after a cycle with both resets released.
    always_ff @(posedge clk) begin
        live <= por_n & hrst_n;
    end

    // R3: a flag falls only after an event on an implemented channel.
    p_fall_needs_event_r3: assert property (@(posedge clk)
        disable iff (!live || !por_n || !hrst_n)
        (|($past(isr_q) & ~isr_q)) |-> (|($past(evt) & EVT_MASK)));

    // R4: a flag rises only after a register write.
    p_rise_needs_write_r4: assert property (@(posedge clk)
        disable iff (!live || !por_n || !hrst_n)
        (|(~$past(isr_q) & isr_q)) |-> $past(isr_wr || cfg_wr));

    // R5: the enable register holds without a write.
    p_cfg_hold_r5: assert property (@(posedge clk)
        disable iff (!live || !por_n || !hrst_n)
        !cfg_wr |=> $stable(cfg_q));

    // R6: disabling the line with no competing event leaves all flags at 1.
    p_line_off_clears_r6: assert property (@(posedge clk)
        disable iff (!live || !por_n || !hrst_n)
        (cfg_wr && wdata[W-1] && ((evt & EVT_MASK & ~wdata) == '0)) |=> (&isr_q));

    // R7: the pull-down only follows a cycle with the line enabled.
    p_pin_needs_enable_r7: assert property (@(posedge clk)
        disable iff (!live || !por_n || !hrst_n)
        int_pd |-> !$past(cfg_q[W-1]));

    // R8: flags all at 1 apart from the power-on flag never pull the line.
    p_por_flag_silent_r8: assert property (@(posedge clk)
        disable iff (!live || !por_n || !hrst_n)
        $past(&(isr_q | POR_ONE)) |-> !int_pd);

endmodule

bind irq_event_ctrl irq_event_ctrl_chk #(
    .W        (W),
    .POR_BIT  (POR_BIT),
    .EVT_MASK (EVT_MASK)
) u_chk (.*);

// File: tb/sim_irq_event_ctrl.sv
// Directed bench for irq_event_ctrl. One task per scenario. Inputs change
// 1 ns after a rising edge; outputs are sampled there too.
module sim_irq_event_ctrl;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        hrst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        isr_wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] evt = '0;
    logic [15:0] cfg_q;
    logic [15:0] isr_q;
    logic        int_pd;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_event_ctrl u0 (
        .clk    (clk),
        .por_n  (por_n),
        .hrst_n (hrst_n),
        .cfg_wr (cfg_wr),
        .isr_wr (isr_wr),
        .wdata  (wdata),
        .evt    (evt),
        .cfg_q  (cfg_q),
        .isr_q  (isr_q),
        .int_pd (int_pd)
    );

    task automatic step();
        @(posedge clk);
        #1;
        cfg_wr = 1'b0; isr_wr = 1'b0; evt = '0; wdata = '0;
        por_n = 1'b1; hrst_n = 1'b1;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] d);
        cfg_wr = 1'b1; wdata = d; step();
    endtask

    task automatic wr_isr(input logic [15:0] d);
        isr_wr = 1'b1; wdata = d; step();
    endtask

    task automatic pulse(input logic [15:0] e);
        evt = e; step();
    endtask

    task automatic t_por();
        por_n = 1'b0; hrst_n = 1'b0; step();
        step();
        chk("R1", "cfg after por", cfg_q, 16'hFFFF);
        chk("R1", "isr after por", isr_q, 16'hFFFB);
        chk("R1", "pin after por", {15'd0, int_pd}, 16'h0000);
    endtask

    task automatic t_hw();
        wr_cfg(16'h0000);
        hrst_n = 1'b0; step();
        chk("R2", "cfg after hw reset", cfg_q, 16'hFFFF);
        chk("R2", "isr after hw reset", isr_q, 16'hFFFF);
    endtask

    task automatic t_por_flag_silent();
        t_por();
        wr_cfg(16'h0000);
        chk("R5", "cfg load zeros", cfg_q, 16'h0000);
        chk("R5", "zero cfg write keeps flags", isr_q, 16'hFFFB);
        step();
        chk("R8", "por flag does not pull", {15'd0, int_pd}, 16'h0000);
    endtask

    task automatic t_host_set();
        wr_isr(16'h0000);
        chk("R4", "zero write cannot clear", isr_q, 16'hFFFB);
        wr_isr(16'h0004);
        chk("R4", "write sets por flag", isr_q, 16'hFFFF);
    endtask

    task automatic t_event_pin();
        pulse(16'h0010);
        chk("R3", "event clears bit 4", isr_q, 16'hFFEF);
        chk("R7", "pin not yet set", {15'd0, int_pd}, 16'h0000);
        step();
        chk("R7", "pin set one cycle later", {15'd0, int_pd}, 16'h0001);
        wr_isr(16'h0000);
        chk("R4", "zero write keeps event flag", isr_q, 16'hFFEF);
        wr_isr(16'h0010);
        chk("R9", "flag set back", isr_q, 16'hFFFF);
        chk("R9", "pin held one more cycle", {15'd0, int_pd}, 16'h0001);
        step();
        chk("R9", "pin released", {15'd0, int_pd}, 16'h0000);
    endtask

    task automatic t_ignored_events();
        pulse(16'h0008);
        chk("R3", "unimplemented channel ignored", isr_q, 16'hFFFF);
        wr_cfg(16'h0010);
        pulse(16'h0010);
        chk("R3", "disabled channel ignored", isr_q, 16'hFFFF);
        step();
        chk("R3", "no pull from ignored event", {15'd0, int_pd}, 16'h0000);
    endtask

    task automatic t_channel_off();
        wr_cfg(16'h0000);
        pulse(16'h0010);
        chk("R3", "event on re-enabled channel", isr_q, 16'hFFEF);
        wr_cfg(16'h0010);
        chk("R5", "cfg reloaded", cfg_q, 16'h0010);
        chk("R5", "channel off sets its flag", isr_q, 16'hFFFF);
        step();
        chk("R9", "pin low after channel off", {15'd0, int_pd}, 16'h0000);
    endtask

    task automatic t_line_off();
        t_por();
        wr_cfg(16'h0000);
        pulse(16'h0010);
        chk("R3", "event with por flag low", isr_q, 16'hFFEB);
        wr_cfg(16'h8000);
        chk("R6", "line off resets all flags", isr_q, 16'hFFFF);
        step();
        chk("R6", "pin low with line off", {15'd0, int_pd}, 16'h0000);
    endtask

    task automatic t_race();
        wr_cfg(16'h0000);
        isr_wr = 1'b1; wdata = 16'h0010; evt = 16'h0010; step();
        chk("R10", "event beats host set", isr_q, 16'hFFEF);
    endtask

    task automatic t_por_priority();
        hrst_n = 1'b1; por_n = 1'b0; step();
        chk("R1", "por image again", isr_q, 16'hFFFB);
        por_n = 1'b0; hrst_n = 1'b0; step();
        chk("R1", "por beats hw reset", isr_q, 16'hFFFB);
        hrst_n = 1'b0; step();
        chk("R2", "hw reset sets por flag", isr_q, 16'hFFFF);
    endtask

    initial begin
        fork
            begin
                t_por();
                t_hw();
                t_por_flag_silent();
                t_host_set();
                t_event_pin();
                t_ignored_events();
                t_channel_off();
                t_line_off();
                t_race();
                t_por_priority();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule